// File: doc/BRIEF.md
# Destination-Indexed Load Miss Tracker

This block follows outstanding data-cache load misses with one tracking slot for every physical destination register, not one slot per missing cache line. Each slot records four things:

- whether it is pending,
- the block address that missed,
- the word position inside the 32-byte line that the load wants,
- the age tag of the load instruction.

Any number of slots may wait on the same block or on different blocks. A miss to a block that already has a live fetch joins that fetch and issues no new memory request.

Memory returns whole blocks after a fixed fetch latency. That latency is modelled outside this block, which only sees the returning fill. When a block comes back, every live slot waiting on it is written in the same cycle, each with its own word of the line. A cache line fill strobe is raised beside those register writes. Register and cache writes each take one cycle, so they appear on the outputs in the cycle after the fill.

A pipeline flush cancels every slot whose tag is younger than the flush tag. Cancelled slots are written by no later fill. If no live slot remains for a block, the fill of that block reaches neither the cache nor any register.

Top module: `inv_miss_tracker`

## Requirements
- R1: While reset is high, and in the first cycle after it falls, `memReqValid`, `cacheFillEn` and all `regWrEn` bits are 0. Reset discards every pending slot, so a later fill writes nothing.
- R2: A miss to a block with no live pending slot raises `memReqValid` in the next cycle, with `memReqBlock` equal to the missing block.
- R3: A miss to a block that another live slot is already waiting on leaves `memReqValid` low in the next cycle.
- R4: In the cycle after a fill, `regWrEn[i]` is 1 for exactly the live slots waiting on the filled block. `regWrData[32*i +: 32]` carries word w of the line, where w is the slot's word position and word w occupies line bits [32w+31:32w].
- R5: `cacheFillEn` is 1 in the cycle after a fill exactly when at least one register is written. In that cycle `cacheFillBlock` and `cacheFillLine` equal the filled block and line.
- R6: A fill leaves slots waiting on other blocks pending, and a later fill of their own block writes them.
- R7: A flush cancels every slot whose tag t satisfies (t - flushTag) mod 2^TAG_W in the range 1 to 2^(TAG_W-1)-1. A slot whose tag equals the flush tag stays pending, and so does any older slot, including across tag wraparound.
- R8: When a flush cancels all slots of a block, the returning fill of that block raises neither `cacheFillEn` nor any `regWrEn`.
- R9: A miss accepted in the same cycle as a fill of the same block is not satisfied by that fill. It issues a new memory request and is written by the next fill of the block.
- R10: When a flush and a fill arrive in the same cycle, the cancelled slots are not written and the surviving matching slots are written.
- R11: A fill clears the slots it writes, so a second fill of the same block writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| allocValid | input | 1 | A new load miss is recorded this cycle |
| allocDest | input | DEST_W | Destination register index of the miss |
| allocBlock | input | BLK_W | Block address of the miss |
| allocWord | input | WOFF_W | Word position within the line |
| allocTag | input | TAG_W | Age tag of the load |
| squashValid | input | 1 | Flush request |
| squashTag | input | TAG_W | Tag of the flushing instruction; younger slots are cancelled |
| fillValid | input | 1 | A block returns from memory |
| fillBlock | input | BLK_W | Address of the returning block |
| fillLine | input | LINE_W | Data of the returning line |
| memReqValid | output | 1 | Fetch request for a newly missing block |
| memReqBlock | output | BLK_W | Block to fetch |
| cacheFillEn | output | 1 | Write the returned line into the cache |
| cacheFillBlock | output | BLK_W | Block address for the cache write |
| cacheFillLine | output | LINE_W | Line data for the cache write |
| regWrEn | output | NUM_DEST | Per-register write enables |
| regWrData | output | NUM_DEST*DATA_W | Per-register write data, register i at bits [32i+31:32i] |

## Verification
Two pairs of functions can meet in one cycle here: a fill with a new miss, and a fill with a flush. Each pair is provoked by applying both inputs on the same stimulus row.

For the fill and new miss, the new miss targets the very block being filled. The test judges that the miss raises a fresh request and is left alone by the current fill, then receives the next fill of that block.

For the fill and flush, the flush cancels one of two slots on the filling block. The write-enable mask must show only the survivor, and the cache strobe must still rise.

// File: rtl/miss_trk_pkg.sv
package miss_trk_pkg;

  // Scalar strobes from control to datapath; per-slot masks travel beside it.
  typedef struct packed {
    logic allocEn;
    logic memReqGo;
    logic cacheFillGo;
  } trk_strobe_t;

endpackage

// File: rtl/miss_trk_ctrl.sv
module miss_trk_ctrl
  import miss_trk_pkg::*;
#(
  parameter int NUM_DEST = 16,
  parameter int BLK_W    = 26,
  parameter int TAG_W    = 6,
  localparam int DEST_W  = $clog2(NUM_DEST)
) (
  input  logic                             allocValid,
  input  logic [DEST_W-1:0]                allocDest,
  input  logic [BLK_W-1:0]                 allocBlock,
  input  logic                             squashValid,
  input  logic [TAG_W-1:0]                 squashTag,
  input  logic                             fillValid,
  input  logic [BLK_W-1:0]                 fillBlock,
  input  logic [NUM_DEST-1:0]              entValid,
  input  logic [NUM_DEST-1:0][BLK_W-1:0]   entBlock,
  input  logic [NUM_DEST-1:0][TAG_W-1:0]   entTag,
  output trk_strobe_t                      strobe,
  output logic [NUM_DEST-1:0]              killMask,
  output logic [NUM_DEST-1:0]              fillHitMask
);

  logic [NUM_DEST-1:0] joinMask;
  logic [NUM_DEST-1:0] liveStay;

  // Per-slot decisions: flush age test, fill match, join candidate.
  for (genvar i = 0; i < NUM_DEST; i++) begin : g_slot
    logic [TAG_W-1:0] ageDiff;
    logic             isYounger;

    assign ageDiff   = entTag[i] - squashTag;
    assign isYounger = (ageDiff != '0) && !ageDiff[TAG_W-1];

    assign killMask[i]    = squashValid && entValid[i] && isYounger;
    assign fillHitMask[i] = fillValid && entValid[i] && !killMask[i]
                            && (entBlock[i] == fillBlock);
    assign liveStay[i]    = entValid[i] && !killMask[i] && !fillHitMask[i];
    assign joinMask[i]    = liveStay[i] && (entBlock[i] == allocBlock)
                            && (allocDest != DEST_W'(i));
  end

  always_comb begin
    strobe.allocEn     = allocValid;
    strobe.memReqGo    = allocValid && (joinMask == '0);
    strobe.cacheFillGo = (fillHitMask != '0);
  end

endmodule

// File: rtl/miss_trk_datapath.sv
module miss_trk_datapath
  import miss_trk_pkg::*;
#(
  parameter int NUM_DEST = 16,
  parameter int BLK_W    = 26,
  parameter int TAG_W    = 6,
  parameter int DATA_W   = 32,
  parameter int WORDS    = 8,
  localparam int DEST_W  = $clog2(NUM_DEST),
  localparam int WOFF_W  = $clog2(WORDS),
  localparam int LINE_W  = DATA_W * WORDS
) (
  input  logic                             clk,
  input  logic                             rst,
  input  trk_strobe_t                      strobe,
  input  logic [NUM_DEST-1:0]              killMask,
  input  logic [NUM_DEST-1:0]              fillHitMask,
  input  logic [DEST_W-1:0]                allocDest,
  input  logic [BLK_W-1:0]                 allocBlock,
  input  logic [WOFF_W-1:0]                allocWord,
  input  logic [TAG_W-1:0]                 allocTag,
  input  logic [BLK_W-1:0]                 fillBlock,
  input  logic [LINE_W-1:0]                fillLine,
  output logic [NUM_DEST-1:0]              entValid,
  output logic [NUM_DEST-1:0][BLK_W-1:0]   entBlock,
  output logic [NUM_DEST-1:0][TAG_W-1:0]   entTag,
  output logic                             memReqValid,
  output logic [BLK_W-1:0]                 memReqBlock,
  output logic                             cacheFillEn,
  output logic [BLK_W-1:0]                 cacheFillBlock,
  output logic [LINE_W-1:0]                cacheFillLine,
  output logic [NUM_DEST-1:0]              regWrEn,
  output logic [NUM_DEST*DATA_W-1:0]       regWrData
);

  logic [NUM_DEST-1:0][WOFF_W-1:0] entWord;

  for (genvar i = 0; i < NUM_DEST; i++) begin : g_entry
    logic takeAlloc;
    assign takeAlloc = strobe.allocEn && (allocDest == DEST_W'(i));

    // Slot state: allocation wins over clearing by flush or fill.
    always_ff @(posedge clk) begin
      if (rst) begin
        entValid[i] <= 1'b0;
        entBlock[i] <= '0;
        entTag[i]   <= '0;
        entWord[i]  <= '0;
      end else if (takeAlloc) begin
        entValid[i] <= 1'b1;
        entBlock[i] <= allocBlock;
        entTag[i]   <= allocTag;
        entWord[i]  <= allocWord;
      end else if (killMask[i] || fillHitMask[i]) begin
        entValid[i] <= 1'b0;
      end
    end

    // Register write port for this destination, one cycle after the fill.
    always_ff @(posedge clk) begin
      if (rst) begin
        regWrEn[i]                     <= 1'b0;
        regWrData[i*DATA_W +: DATA_W]  <= '0;
      end else begin
        regWrEn[i] <= fillHitMask[i];
        if (fillHitMask[i])
          regWrData[i*DATA_W +: DATA_W] <= fillLine[entWord[i]*DATA_W +: DATA_W];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      memReqValid    <= 1'b0;
      memReqBlock    <= '0;
      cacheFillEn    <= 1'b0;
      cacheFillBlock <= '0;
      cacheFillLine  <= '0;
    end else begin
      memReqValid <= strobe.memReqGo;
      if (strobe.memReqGo) memReqBlock <= allocBlock;
      cacheFillEn <= strobe.cacheFillGo;
      if (strobe.cacheFillGo) begin
        cacheFillBlock <= fillBlock;
        cacheFillLine  <= fillLine;
      end
    end
  end

endmodule

// File: rtl/inv_miss_tracker.sv
module inv_miss_tracker
  import miss_trk_pkg::*;
#(
  parameter int NUM_DEST = 16,
  parameter int BLK_W    = 26,
  parameter int TAG_W    = 6,
  parameter int DATA_W   = 32,
  parameter int WORDS    = 8,
  localparam int DEST_W  = $clog2(NUM_DEST),
  localparam int WOFF_W  = $clog2(WORDS),
  localparam int LINE_W  = DATA_W * WORDS
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        allocValid,
  input  logic [DEST_W-1:0]           allocDest,
  input  logic [BLK_W-1:0]            allocBlock,
  input  logic [WOFF_W-1:0]           allocWord,
  input  logic [TAG_W-1:0]            allocTag,
  input  logic                        squashValid,
  input  logic [TAG_W-1:0]            squashTag,
  input  logic                        fillValid,
  input  logic [BLK_W-1:0]            fillBlock,
  input  logic [LINE_W-1:0]           fillLine,
  output logic                        memReqValid,
  output logic [BLK_W-1:0]            memReqBlock,
  output logic                        cacheFillEn,
  output logic [BLK_W-1:0]            cacheFillBlock,
  output logic [LINE_W-1:0]           cacheFillLine,
  output logic [NUM_DEST-1:0]         regWrEn,
  output logic [NUM_DEST*DATA_W-1:0]  regWrData
);

  trk_strobe_t                     strobe;
  logic [NUM_DEST-1:0]             killMask;
  logic [NUM_DEST-1:0]             fillHitMask;
  logic [NUM_DEST-1:0]             entValid;
  logic [NUM_DEST-1:0][BLK_W-1:0]  entBlock;
  logic [NUM_DEST-1:0][TAG_W-1:0]  entTag;

  miss_trk_ctrl #(
    .NUM_DEST(NUM_DEST), .BLK_W(BLK_W), .TAG_W(TAG_W)
  ) ctrl (
    .allocValid (allocValid),
    .allocDest  (allocDest),
    .allocBlock (allocBlock),
    .squashValid(squashValid),
    .squashTag  (squashTag),
    .fillValid  (fillValid),
    .fillBlock  (fillBlock),
    .entValid   (entValid),
    .entBlock   (entBlock),
    .entTag     (entTag),
    .strobe     (strobe),
    .killMask   (killMask),
    .fillHitMask(fillHitMask)
  );

  miss_trk_datapath #(
    .NUM_DEST(NUM_DEST), .BLK_W(BLK_W), .TAG_W(TAG_W),
    .DATA_W(DATA_W), .WORDS(WORDS)
  ) dpath (
    .clk           (clk),
    .rst           (rst),
    .strobe        (strobe),
    .killMask      (killMask),
    .fillHitMask   (fillHitMask),
    .allocDest     (allocDest),
    .allocBlock    (allocBlock),
    .allocWord     (allocWord),
    .allocTag      (allocTag),
    .fillBlock     (fillBlock),
    .fillLine      (fillLine),
    .entValid      (entValid),
    .entBlock      (entBlock),
    .entTag        (entTag),
    .memReqValid   (memReqValid),
    .memReqBlock   (memReqBlock),
    .cacheFillEn   (cacheFillEn),
    .cacheFillBlock(cacheFillBlock),
    .cacheFillLine (cacheFillLine),
    .regWrEn       (regWrEn),
    .regWrData     (regWrData)
  );

endmodule

// File: rtl/inv_miss_tracker_chk.sv
module inv_miss_tracker_chk #(
  parameter int NUM_DEST = 16,
  parameter int BLK_W    = 26,
  parameter int DATA_W   = 32,
  parameter int WORDS    = 8,
  localparam int LINE_W  = DATA_W * WORDS
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 allocValid,
  input logic [BLK_W-1:0]     allocBlock,
  input logic                 fillValid,
  input logic [BLK_W-1:0]     fillBlock,
  input logic [LINE_W-1:0]    fillLine,
  input logic                 memReqValid,
  input logic [BLK_W-1:0]     memReqBlock,
  input logic                 cacheFillEn,
  input logic [BLK_W-1:0]     cacheFillBlock,
  input logic [LINE_W-1:0]    cacheFillLine,
  input logic [NUM_DEST-1:0]  regWrEn
);

  // R1: outputs quiet in the first cycle after reset drops
  a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!memReqValid && !cacheFillEn && regWrEn == '0));

  // R2: a request only follows a miss, and names that miss's block
  a_r2_req_from_alloc: assert property (@(posedge clk) disable iff (rst)
    memReqValid |-> ($past(allocValid) && memReqBlock == $past(allocBlock)));

  // R4: register writes only follow a fill
  a_r4_write_from_fill: assert property (@(posedge clk) disable iff (rst)
    (regWrEn != '0) |-> $past(fillValid));

  // R5: register writes come with a cache fill of the returned block
  a_r5_cache_with_writes: assert property (@(posedge clk) disable iff (rst)
    (regWrEn != '0) |-> cacheFillEn);

  a_r5_cache_fields: assert property (@(posedge clk) disable iff (rst)
    cacheFillEn |-> ($past(fillValid) && cacheFillBlock == $past(fillBlock)
                     && cacheFillLine == $past(fillLine)));

endmodule

bind inv_miss_tracker inv_miss_tracker_chk #(
  .NUM_DEST(NUM_DEST), .BLK_W(BLK_W), .DATA_W(DATA_W), .WORDS(WORDS)
) chk (.*);

// File: tb/inv_miss_tracker_test.sv
module inv_miss_tracker_test;

  localparam int CLK_PERIOD = 10;
  localparam int NUM_DEST   = 16;
  localparam int BLK_W      = 26;
  localparam int TAG_W      = 6;
  localparam int DATA_W     = 32;
  localparam int WORDS      = 8;
  localparam int LINE_W     = DATA_W * WORDS;
  localparam int NROW       = 24;

  typedef struct packed {
    logic        aV;
    logic [3:0]  aD;
    logic [7:0]  aB;
    logic [5:0]  aT;
    logic        sV;
    logic [5:0]  sT;
    logic        fV;
    logic [7:0]  fB;
    logic        eReq;
    logic [15:0] eWr;
    logic        eCache;
  } row_t;

  // Each slot d requests word d%8. Outputs are checked one edge after the row.
  localparam row_t ROWS [NROW] = '{
    '{1'b0, 4'd0,  8'h00, 6'd0,  1'b0, 6'd0,  1'b0, 8'h00, 1'b0, 16'h0000, 1'b0},
    '{1'b1, 4'd1,  8'h10, 6'd1,  1'b0, 6'd0,  1'b0, 8'h00, 1'b1, 16'h0000, 1'b0},
    '{1'b1, 4'd2,  8'h10, 6'd2,  1'b0, 6'd0,  1'b0, 8'h00, 1'b0, 16'h0000, 1'b0},
    '{1'b1, 4'd3,  8'h20, 6'd3,  1'b0, 6'd0,  1'b0, 8'h00, 1'b1, 16'h0000, 1'b0},
    '{1'b1, 4'd5,  8'h10, 6'd5,  1'b0, 6'd0,  1'b0, 8'h00, 1'b0, 16'h0000, 1'b0},
    '{1'b0, 4'd0,  8'h00, 6'd0,  1'b0, 6'd0,  1'b1, 8'h10, 1'b0, 16'h0026, 1'b1},
    '{1'b0, 4'd0,  8'h00, 6'd0,  1'b0, 6'd0,  1'b1, 8'h10, 1'b0, 16'h0000, 1'b0},
    '{1'b0, 4'd0,  8'h00, 6'd0,  1'b0, 6'd0,  1'b1, 8'h20, 1'b0, 16'h0008, 1'b1},
    '{1'b1, 4'd4,  8'h30, 6'd8,  1'b0, 6'd0,  1'b0, 8'h00, 1'b1, 16'h0000, 1'b0},
    '{1'b1, 4'd6,  8'h30, 6'd9,  1'b0, 6'd0,  1'b0, 8'h00, 1'b0, 16'h0000, 1'b0},
    '{1'b1, 4'd7,  8'h40, 6'd10, 1'b0, 6'd0,  1'b0, 8'h00, 1'b1, 16'h0000, 1'b0},
    '{1'b0, 4'd0,  8'h00, 6'd0,  1'b1, 6'd8,  1'b0, 8'h00, 1'b0, 16'h0000, 1'b0},
    '{1'b0, 4'd0,  8'h00, 6'd0,  1'b0, 6'd0,  1'b1, 8'h40, 1'b0, 16'h0000, 1'b0},
    '{1'b0, 4'd0,  8'h00, 6'd0,  1'b0, 6'd0,  1'b1, 8'h30, 1'b0, 16'h0010, 1'b1},
    '{1'b1, 4'd8,  8'h50, 6'd11, 1'b0, 6'd0,  1'b0, 8'h00, 1'b1, 16'h0000, 1'b0},
    '{1'b1, 4'd9,  8'h50, 6'd12, 1'b0, 6'd0,  1'b1, 8'h50, 1'b1, 16'h0100, 1'b1},
    '{1'b0, 4'd0,  8'h00, 6'd0,  1'b0, 6'd0,  1'b1, 8'h50, 1'b0, 16'h0200, 1'b1},
    '{1'b1, 4'd10, 8'h60, 6'd13, 1'b0, 6'd0,  1'b0, 8'h00, 1'b1, 16'h0000, 1'b0},
    '{1'b1, 4'd11, 8'h60, 6'd14, 1'b0, 6'd0,  1'b0, 8'h00, 1'b0, 16'h0000, 1'b0},
    '{1'b0, 4'd0,  8'h00, 6'd0,  1'b1, 6'd13, 1'b1, 8'h60, 1'b0, 16'h0400, 1'b1},
    '{1'b1, 4'd12, 8'h70, 6'd62, 1'b0, 6'd0,  1'b0, 8'h00, 1'b1, 16'h0000, 1'b0},
    '{1'b1, 4'd13, 8'h70, 6'd1,  1'b0, 6'd0,  1'b0, 8'h00, 1'b0, 16'h0000, 1'b0},
    '{1'b0, 4'd0,  8'h00, 6'd0,  1'b1, 6'd63, 1'b0, 8'h00, 1'b0, 16'h0000, 1'b0},
    '{1'b0, 4'd0,  8'h00, 6'd0,  1'b0, 6'd0,  1'b1, 8'h70, 1'b0, 16'h1000, 1'b1}
  };

  logic                        clk = 1'b0;
  logic                        rst = 1'b1;
  logic                        allocValid = 1'b0;
  logic [3:0]                  allocDest = '0;
  logic [BLK_W-1:0]            allocBlock = '0;
  logic [2:0]                  allocWord = '0;
  logic [TAG_W-1:0]            allocTag = '0;
  logic                        squashValid = 1'b0;
  logic [TAG_W-1:0]            squashTag = '0;
  logic                        fillValid = 1'b0;
  logic [BLK_W-1:0]            fillBlock = '0;
  logic [LINE_W-1:0]           fillLine = '0;
  logic                        memReqValid;
  logic [BLK_W-1:0]            memReqBlock;
  logic                        cacheFillEn;
  logic [BLK_W-1:0]            cacheFillBlock;
  logic [LINE_W-1:0]           cacheFillLine;
  logic [NUM_DEST-1:0]         regWrEn;
  logic [NUM_DEST*DATA_W-1:0]  regWrData;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  inv_miss_tracker uut (.*);

  function automatic logic [DATA_W-1:0] wordOf(input logic [7:0] blk, input int w);
    return {8'hC0, blk, 8'(w), 8'h5A};
  endfunction

  function automatic logic [LINE_W-1:0] lineOf(input logic [7:0] blk);
    logic [LINE_W-1:0] l;
    for (int w = 0; w < WORDS; w++) l[w*DATA_W +: DATA_W] = wordOf(blk, w);
    return l;
  endfunction

  function automatic string reqOf(input int r);
    case (r)
      0:                          return "R1";
      1, 3, 8, 10, 14, 17, 20:    return "R2";
      2, 4, 9, 18, 21:            return "R3";
      5:                          return "R4";
      6:                          return "R11";
      7:                          return "R6";
      12:                         return "R8";
      15, 16:                     return "R9";
      19:                         return "R10";
      default:                    return "R7";
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic clearInputs();
    allocValid = 1'b0; squashValid = 1'b0; fillValid = 1'b0;
  endtask

  task automatic finish();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1: quiet during reset
    check(!memReqValid && !cacheFillEn && regWrEn == '0, "R1", "outputs in reset",
          {cacheFillEn, memReqValid, 16'(regWrEn)}, 64'h0);
    @(negedge clk) rst = 1'b0;

    for (int r = 0; r < NROW; r++) begin
      row_t v;
      v = ROWS[r];
      @(negedge clk);
      allocValid  = v.aV;
      allocDest   = v.aD;
      allocBlock  = BLK_W'(v.aB);
      allocWord   = v.aD[2:0];
      allocTag    = v.aT;
      squashValid = v.sV;
      squashTag   = v.sT;
      fillValid   = v.fV;
      fillBlock   = BLK_W'(v.fB);
      fillLine    = lineOf(v.fB);
      @(posedge clk);
      #1;
      check(memReqValid == v.eReq, reqOf(r), $sformatf("memReqValid row %0d", r),
            64'(memReqValid), 64'(v.eReq));
      if (v.eReq)
        check(memReqBlock == BLK_W'(v.aB), "R2", $sformatf("memReqBlock row %0d", r),
              64'(memReqBlock), 64'(v.aB));
      check(regWrEn == v.eWr, reqOf(r), $sformatf("regWrEn row %0d", r),
            64'(regWrEn), 64'(v.eWr));
      check(cacheFillEn == v.eCache, "R5", $sformatf("cacheFillEn row %0d", r),
            64'(cacheFillEn), 64'(v.eCache));
      if (v.eCache) begin
        check(cacheFillBlock == BLK_W'(v.fB), "R5", $sformatf("cacheFillBlock row %0d", r),
              64'(cacheFillBlock), 64'(v.fB));
        check(cacheFillLine == lineOf(v.fB), "R5", $sformatf("cacheFillLine row %0d", r),
              64'(cacheFillLine), 64'(lineOf(v.fB)));
      end
      for (int i = 0; i < NUM_DEST; i++)
        if (v.eWr[i])
          check(regWrData[i*DATA_W +: DATA_W] == wordOf(v.fB, i % WORDS), "R4",
                $sformatf("regWrData[%0d] row %0d", i, r),
                64'(regWrData[i*DATA_W +: DATA_W]), 64'(wordOf(v.fB, i % WORDS)));
    end

    // R1: reset discards a pending slot
    @(negedge clk);
    clearInputs();
    allocValid = 1'b1; allocDest = 4'd0; allocBlock = BLK_W'(8'h11);
    allocWord = 3'd0; allocTag = 6'd20;
    @(negedge clk);
    clearInputs();
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    fillValid = 1'b1; fillBlock = BLK_W'(8'h11); fillLine = lineOf(8'h11);
    @(posedge clk);
    #1;
    check(regWrEn == '0 && !cacheFillEn, "R1", "fill after reset",
          {cacheFillEn, 16'(regWrEn)}, 64'h0);
    @(negedge clk);
    clearInputs();
    @(negedge clk);
    finish();
  end

endmodule